// File: doc/BRIEF.md
# Dual Post-Divider Bank with Output Crosspoint

This block sits behind a frequency synthesizer and turns two input clocks, a VCO clock and a reference clock, into six independently routed clock outputs. Two divider banks each pick one of the two input clocks as their source. Each bank then produces three taps: a programmable divide-by-N and two fixed ratios. Bank 1 provides /2 and /3, and bank 2 provides /2 and /4. A per-output 3-bit select routes the reference clock, one of the six bank taps, or a forced-low level to each output.

Every output also has an enable. The block gives a data value and a drive enable to the pad cell for each output. A disabled output has its drive enable low, so the pad is high-impedance, and its data value held low.

Configuration arrives as a parallel register image and is treated as quasi-static. The source bits are changed only while reset is held. N may change while the block runs and takes effect cleanly at the end of the current divider period. Because all counters of a bank share one source clock and one synchronous reset, the fixed taps stay rising-edge aligned with the /N tap whenever N meets the ratio conditions listed below.

Top module: `xdiv_crosspoint`

## Requirements
- R1: While `rst_n` is low every bank tap is low. On the first source edge after release, all taps of a bank rise together.
- R2: Bit 7 of a bank control byte selects its source clock: 1 selects `vco_clk` and 0 selects `ref_clk`.
- R3: The /N tap of a bank, with N held in bits 6..0 of its control byte, has a period of N source cycles. It is high for floor(N/2) cycles and low for the rest, over the whole legal range 4 to 127.
- R4: Bank 1 offers fixed /2 and /3 taps, and bank 2 offers fixed /2 and /4 taps. Each fixed tap is high for floor(ratio/2) source cycles per period.
- R5: Select codes are: 000 reference clock, 001 bank 1 /N, 010 bank 1 /2, 011 bank 1 /3, 100 bank 2 /N, 101 bank 2 /2, 110 bank 2 /4, 111 reserved.
- R6: The select of output k occupies bits [17-3k : 15-3k] of `xsel_image`, so output 0 holds the top three bits.
- R7: Bit k of `oe_mask` enables output k. When it is 0, `clk_oe[k]` is 0 and `clk_o[k]` stays low.
- R8: An enabled output with select 111 stays low.
- R9: A new N value is taken only when the /N counter completes its period. The period in progress finishes with the old N.
- R10: In bank 1, every rising edge of /N coincides with a rising edge of /2 when N is a multiple of 4, and with a rising edge of /3 when N equals 6.
- R11: In bank 2, every rising edge of /N coincides with a rising edge of /2 when N is a multiple of 4, and with a rising edge of /4 when N is a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock, selectable source for either bank |
| ref_clk | input | 1 | Reference clock, bank source and direct output option |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each bank's source domain |
| oe_mask | input | 6 | Per-output enable, bit k for output k |
| b1_ctl | input | 8 | Bank 1 control: bit 7 source select, bits 6..0 N |
| b2_ctl | input | 8 | Bank 2 control: bit 7 source select, bits 6..0 N |
| xsel_image | input | 18 | Six packed 3-bit output selects, output 0 in the top bits |
| clk_o | output | 6 | Output clock values to the pad cells |
| clk_oe | output | 6 | Pad drive enables; 0 means high-impedance |

## Verification
The hardest situation to reach from the ports is a change of N in the middle of a divider period. The stimulus first waits, sampling after each source edge, until the /N output has just risen. It then rewrites N within that same source cycle. The next stretch of samples must show the old high and low phases completing before the new ratio appears. The alignment rules are reached in the same way: N is set to a multiple of 4, to 6 and to a multiple of 8 under reset, and each rising edge of the /N output is compared with the auxiliary tap routed to another output.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;

   // Crosspoint source codes; the numeric values are the select encoding.
   typedef enum logic [2:0] {
      SRC_REF     = 3'd0,
      SRC_B1_N    = 3'd1,
      SRC_B1_HALF = 3'd2,
      SRC_B1_AUX  = 3'd3,
      SRC_B2_N    = 3'd4,
      SRC_B2_HALF = 3'd5,
      SRC_B2_AUX  = 3'd6,
      SRC_OFF     = 3'd7
   } xsel_e;

   localparam int SEL_W    = 3;
   localparam int NUM_TAPS = 3;
   localparam int TAP_N    = 0;
   localparam int TAP_HALF = 1;
   localparam int TAP_AUX  = 2;

endpackage

// File: rtl/xdiv_ctr.sv
// Counter-based clock divider. The ratio is taken at reset and again at
// each terminal count, so a period in progress is never cut short.
module xdiv_ctr #(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] ratio_i,
   output logic          tap_o
);

   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q, ratio_q;
   logic [CW-1:0] cnt_nxt, ratio_nxt, half_nxt;
   logic          wrap;

   if (CW < 2) begin : g_bad_cw
      $error("xdiv_ctr: CW must be at least 2");
   end

   assign wrap = (cnt_q == (ratio_q - ONE));

   always_comb begin
      ratio_nxt = wrap ? ratio_i : ratio_q;
      cnt_nxt   = wrap ? '0 : (cnt_q + ONE);
      half_nxt  = ratio_nxt >> 1;
   end

   // Reset parks the counter on its terminal value so the first source
   // edge after release wraps and starts a high phase.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ratio_q <= ratio_i;
         cnt_q   <= ratio_i - ONE;
         tap_o   <= 1'b0;
      end else begin
         ratio_q <= ratio_nxt;
         cnt_q   <= cnt_nxt;
         tap_o   <= (cnt_nxt < half_nxt);
      end
   end

endmodule

// File: rtl/xdiv_bank.sv
// One post-divider bank: source mux plus /N, /2 and one auxiliary ratio.
module xdiv_bank
   import xdiv_pkg::*;
#(
   parameter int CW        = 7,
   parameter int AUX_RATIO = 3
) (
   input  logic                vco_clk,
   input  logic                ref_clk,
   input  logic                rst_n,
   input  logic [CW:0]         ctl_i,
   output logic                src_clk_o,
   output logic [NUM_TAPS-1:0] taps_o
);

   localparam logic [CW-1:0] HALF_R = CW'(2);
   localparam logic [CW-1:0] AUX_R  = CW'(AUX_RATIO);

   if (AUX_RATIO < 2 || AUX_RATIO >= (1 << CW)) begin : g_bad_aux
      $error("xdiv_bank: AUX_RATIO out of range for CW");
   end

   assign src_clk_o = ctl_i[CW] ? vco_clk : ref_clk;

   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      logic [CW-1:0] ratio;
      if (t == TAP_N) begin : g_prog
         assign ratio = ctl_i[CW-1:0];
      end else if (t == TAP_HALF) begin : g_half
         assign ratio = HALF_R;
      end else begin : g_aux
         assign ratio = AUX_R;
      end
      xdiv_ctr #(.CW(CW)) i_ctr (
         .clk     (src_clk_o),
         .rst_n   (rst_n),
         .ratio_i (ratio),
         .tap_o   (taps_o[t])
      );
   end

endmodule

// File: rtl/xdiv_lane.sv
// One crosspoint output: source select, reserved-code blanking and enable.
module xdiv_lane
   import xdiv_pkg::*;
(
   input  logic                ref_clk,
   input  logic [SEL_W-1:0]    sel_i,
   input  logic                en_i,
   input  logic [NUM_TAPS-1:0] taps1_i,
   input  logic [NUM_TAPS-1:0] taps2_i,
   output logic                clk_o,
   output logic                oe_o
);

   logic picked;

   always_comb begin
      case (xsel_e'(sel_i))
         SRC_REF:     picked = ref_clk;
         SRC_B1_N:    picked = taps1_i[TAP_N];
         SRC_B1_HALF: picked = taps1_i[TAP_HALF];
         SRC_B1_AUX:  picked = taps1_i[TAP_AUX];
         SRC_B2_N:    picked = taps2_i[TAP_N];
         SRC_B2_HALF: picked = taps2_i[TAP_HALF];
         SRC_B2_AUX:  picked = taps2_i[TAP_AUX];
         default:     picked = 1'b0;
      endcase
   end

   assign clk_o = en_i & picked;
   assign oe_o  = en_i;

endmodule

// File: rtl/xdiv_crosspoint.sv
// Two divider banks feeding a per-output crosspoint.
module xdiv_crosspoint
   import xdiv_pkg::*;
#(
   parameter int CW      = 7,
   parameter int NUM_OUT = 6,
   parameter int B1_AUX  = 3,
   parameter int B2_AUX  = 4
) (
   input  logic                     vco_clk,
   input  logic                     ref_clk,
   input  logic                     rst_n,
   input  logic [NUM_OUT-1:0]       oe_mask,
   input  logic [CW:0]              b1_ctl,
   input  logic [CW:0]              b2_ctl,
   input  logic [SEL_W*NUM_OUT-1:0] xsel_image,
   output logic [NUM_OUT-1:0]       clk_o,
   output logic [NUM_OUT-1:0]       clk_oe
);

   localparam int XSW = SEL_W * NUM_OUT;

   if (NUM_OUT < 1) begin : g_bad_out
      $error("xdiv_crosspoint: NUM_OUT must be at least 1");
   end
   if (CW < 3) begin : g_bad_cw
      $error("xdiv_crosspoint: CW must be at least 3");
   end

   logic                bclk1, bclk2;
   logic [NUM_TAPS-1:0] taps1, taps2;

   xdiv_bank #(.CW(CW), .AUX_RATIO(B1_AUX)) i_bank1 (
      .vco_clk   (vco_clk),
      .ref_clk   (ref_clk),
      .rst_n     (rst_n),
      .ctl_i     (b1_ctl),
      .src_clk_o (bclk1),
      .taps_o    (taps1)
   );

   xdiv_bank #(.CW(CW), .AUX_RATIO(B2_AUX)) i_bank2 (
      .vco_clk   (vco_clk),
      .ref_clk   (ref_clk),
      .rst_n     (rst_n),
      .ctl_i     (b2_ctl),
      .src_clk_o (bclk2),
      .taps_o    (taps2)
   );

   // Output 0 takes the most significant select field.
   for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
      xdiv_lane i_lane (
         .ref_clk (ref_clk),
         .sel_i   (xsel_image[XSW-1-SEL_W*k -: SEL_W]),
         .en_i    (oe_mask[k]),
         .taps1_i (taps1),
         .taps2_i (taps2),
         .clk_o   (clk_o[k]),
         .oe_o    (clk_oe[k])
      );
   end

endmodule

// File: rtl/xdiv_crosspoint_chk.sv
module xdiv_crosspoint_chk #(
   parameter int CW      = 7,
   parameter int NUM_OUT = 6
) (
   input logic                 ref_clk,
   input logic                 rst_n,
   input logic                 bclk1,
   input logic                 bclk2,
   input logic [2:0]           taps1,
   input logic [2:0]           taps2,
   input logic [CW-1:0]        b1_n,
   input logic [CW-1:0]        b2_n,
   input logic [3*NUM_OUT-1:0] xsel_image,
   input logic [NUM_OUT-1:0]   clk_o,
   input logic [NUM_OUT-1:0]   clk_oe
);

   // Flags: the condition has held for every N value seen since reset.
   logic b1_m4, b1_is6, b2_m4, b2_m8;

   always_ff @(posedge bclk1) begin
      if (!rst_n) begin
         b1_m4  <= ((b1_n % CW'(4)) == '0);
         b1_is6 <= (b1_n == CW'(6));
      end else begin
         b1_m4  <= b1_m4 && ((b1_n % CW'(4)) == '0);
         b1_is6 <= b1_is6 && (b1_n == CW'(6));
      end
   end

   always_ff @(posedge bclk2) begin
      if (!rst_n) begin
         b2_m4 <= ((b2_n % CW'(4)) == '0);
         b2_m8 <= ((b2_n % CW'(8)) == '0);
      end else begin
         b2_m4 <= b2_m4 && ((b2_n % CW'(4)) == '0);
         b2_m8 <= b2_m8 && ((b2_n % CW'(8)) == '0);
      end
   end

   p_b1_half_align_r10: assert property (@(posedge bclk1) disable iff (!rst_n)
      (b1_m4 && $rose(taps1[0])) |-> $rose(taps1[1]));

   p_b1_third_align_r10: assert property (@(posedge bclk1) disable iff (!rst_n)
      (b1_is6 && $rose(taps1[0])) |-> $rose(taps1[2]));

   p_b2_half_align_r11: assert property (@(posedge bclk2) disable iff (!rst_n)
      (b2_m4 && $rose(taps2[0])) |-> $rose(taps2[1]));

   p_b2_quarter_align_r11: assert property (@(posedge bclk2) disable iff (!rst_n)
      (b2_m8 && $rose(taps2[0])) |-> $rose(taps2[2]));

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
      p_off_low_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
         !clk_oe[k] |-> !clk_o[k]);

      p_reserved_low_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
         (xsel_image[3*NUM_OUT-1-3*k -: 3] == 3'b111) |-> !clk_o[k]);
   end

endmodule

bind xdiv_crosspoint xdiv_crosspoint_chk #(.CW(CW), .NUM_OUT(NUM_OUT)) i_chk (
   .ref_clk    (ref_clk),
   .rst_n      (rst_n),
   .bclk1      (bclk1),
   .bclk2      (bclk2),
   .taps1      (taps1),
   .taps2      (taps2),
   .b1_n       (b1_ctl[CW-1:0]),
   .b2_n       (b2_ctl[CW-1:0]),
   .xsel_image (xsel_image),
   .clk_o      (clk_o),
   .clk_oe     (clk_oe)
);

// File: tb/test_xdiv_crosspoint.sv
module test_xdiv_crosspoint;
   timeunit 1ns;
   timeprecision 100ps;

   logic        ref_clk = 1'b0;
   logic        vco_clk = 1'b0;
   logic        rst_n   = 1'b0;
   logic [5:0]  oe_mask = '0;
   logic [7:0]  b1_ctl  = 8'h08;
   logic [7:0]  b2_ctl  = 8'h08;
   logic [17:0] xsel_image = '0;
   logic [5:0]  clk_o, clk_oe;

   int n_checks = 0;
   int n_errs   = 0;

   always #4   ref_clk = ~ref_clk;   // 125 MHz
   always #2.5 vco_clk = ~vco_clk;

   xdiv_crosspoint i_xdiv_crosspoint (
      .vco_clk    (vco_clk),
      .ref_clk    (ref_clk),
      .rst_n      (rst_n),
      .oe_mask    (oe_mask),
      .b1_ctl     (b1_ctl),
      .b2_ctl     (b2_ctl),
      .xsel_image (xsel_image),
      .clk_o      (clk_o),
      .clk_oe     (clk_oe)
   );

   function automatic logic [17:0] pack(input logic [2:0] s0, s1, s2, s3, s4, s5);
      return {s0, s1, s2, s3, s4, s5};
   endfunction

   task automatic report(input bit ok, input string tag, input string what,
                         input int got, input int expv);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
      end
   endtask

   task automatic src_step(input bit use_vco);
      if (use_vco) @(posedge vco_clk);
      else         @(posedge ref_clk);
      #1;
   endtask

   task automatic apply(input logic [7:0] c1, c2, input logic [17:0] xs,
                        input logic [5:0] oe);
      rst_n = 1'b0;
      b1_ctl = c1; b2_ctl = c2; xsel_image = xs; oe_mask = oe;
      repeat (4) @(posedge ref_clk);
      @(negedge ref_clk);
      rst_n = 1'b1;
   endtask

   task automatic check_div(input int k, input bit v, input int ratio, input string tag);
      logic smp [0:599];
      int r, bad, got, expv;
      for (int i = 0; i < 4*ratio+2; i++) begin
         src_step(v);
         smp[i] = clk_o[k];
      end
      r = -1;
      for (int i = 1; i < 4*ratio+2; i++)
         if (r < 0 && smp[i] && !smp[i-1]) r = i;
      if (r < 0) begin
         report(1'b0, tag, $sformatf("out%0d no rising edge", k), 0, 1);
         return;
      end
      bad = -1; got = 0; expv = 0;
      for (int j = 0; j < 2*ratio; j++) begin
         if (bad < 0 && (smp[r+j] != ((j % ratio) < (ratio/2)))) begin
            bad = j; got = int'(smp[r+j]); expv = int'((j % ratio) < (ratio/2));
         end
      end
      report(bad < 0, tag, $sformatf("out%0d /%0d sample %0d after rise", k, ratio, bad),
             got, expv);
   endtask

   task automatic check_low(input int k, input bit exp_oe, input string tag);
      int bad = 0;
      for (int i = 0; i < 30; i++) begin
         @(posedge ref_clk); #1;
         if (clk_o[k] !== 1'b0 || clk_oe[k] !== exp_oe) bad++;
         @(posedge vco_clk); #1;
         if (clk_o[k] !== 1'b0 || clk_oe[k] !== exp_oe) bad++;
      end
      report(bad == 0, tag, $sformatf("out%0d held low, bad samples", k), bad, 0);
   endtask

   task automatic check_align(input int kn, input int ka, input bit v, input string tag);
      logic pn, pa;
      int rises = 0, miss = 0;
      src_step(v);
      pn = clk_o[kn]; pa = clk_o[ka];
      for (int i = 0; i < 70; i++) begin
         src_step(v);
         if (clk_o[kn] && !pn) begin
            rises++;
            if (!(clk_o[ka] && !pa)) miss++;
         end
         pn = clk_o[kn]; pa = clk_o[ka];
      end
      report(miss == 0 && rises >= 2, tag,
             $sformatf("out%0d/out%0d unaligned rises (of %0d)", kn, ka, rises), miss, 0);
   endtask

   // R1: reset state and common first edge
   task automatic t_reset();
      rst_n = 1'b0;
      b1_ctl = 8'h08; b2_ctl = 8'h08; oe_mask = 6'h3F;
      xsel_image = pack(3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6);
      repeat (4) @(posedge ref_clk);
      #1 report(clk_o == 6'b000000, "R1", "outputs during reset", int'(clk_o), 0);
      @(negedge ref_clk);
      rst_n = 1'b1;
      @(posedge ref_clk); #1;
      report(clk_o == 6'b111111, "R1", "first edge after release", int'(clk_o), 63);
      @(posedge ref_clk); #1;
      report(clk_o == 6'b101001, "R1", "second edge after release", int'(clk_o), 41);
   endtask

   // R3 R4 R5: every code routed, bank 1 on ref, bank 2 on vco (R2)
   task automatic t_routes();
      apply(8'h05, 8'h87, pack(3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6), 6'h3F);
      check_div(0, 1'b0, 5, "R3 R5 b1 /N");
      check_div(1, 1'b0, 2, "R4 R5 b1 /2");
      check_div(2, 1'b0, 3, "R4 R5 b1 /3");
      check_div(3, 1'b1, 7, "R2 R3 b2 /N on vco");
      check_div(4, 1'b1, 2, "R4 R5 b2 /2");
      check_div(5, 1'b1, 4, "R4 R5 b2 /4");
   endtask

   // R6: reversed packing, reference passthrough on the last output
   task automatic t_packing();
      int bad = 0;
      apply(8'h05, 8'h87, pack(3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd0), 6'h3F);
      check_div(0, 1'b1, 4, "R6 out0 b2 /4");
      check_div(2, 1'b1, 7, "R6 out2 b2 /N");
      check_div(3, 1'b0, 3, "R6 out3 b1 /3");
      for (int i = 0; i < 6; i++) begin
         @(posedge ref_clk); #1; if (clk_o[5] !== 1'b1) bad++;
         @(negedge ref_clk); #1; if (clk_o[5] !== 1'b0) bad++;
      end
      report(bad == 0, "R6 R5", "out5 reference passthrough mismatches", bad, 0);
   endtask

   // R2 R3: boundary ratios, bank 1 on vco with N=4, bank 2 on ref with N=127
   task automatic t_bounds();
      apply(8'h84, 8'h7F, pack(3'd1, 3'd4, 3'd7, 3'd7, 3'd7, 3'd7), 6'h03);
      check_div(0, 1'b1, 4, "R2 R3 N=4 on vco");
      check_div(1, 1'b0, 127, "R3 N=127 on ref");
   endtask

   // R7 R8: disabled output and reserved code
   task automatic t_enable();
      apply(8'h05, 8'h08, pack(3'd1, 3'd1, 3'd7, 3'd0, 3'd0, 3'd0), 6'b000110);
      check_low(0, 1'b0, "R7 disabled");
      check_div(1, 1'b0, 5, "R7 neighbour enabled");
      check_low(2, 1'b1, "R8 reserved code");
   endtask

   // R9: N rewritten right after a rising edge of /N
   task automatic t_reload();
      logic prev;
      int bad = 0, got = 0, expv = 0, first = -1;
      logic [14:1] expect_seq = 14'b10011000001111; // index 1 in bit 1
      apply(8'h0A, 8'h08, pack(3'd1, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7), 6'h01);
      src_step(1'b0);
      prev = clk_o[0];
      for (int i = 0; i < 40; i++) begin
         src_step(1'b0);
         if (clk_o[0] && !prev) break;
         prev = clk_o[0];
      end
      b1_ctl = 8'h04;
      for (int j = 1; j <= 14; j++) begin
         src_step(1'b0);
         if (clk_o[0] !== expect_seq[j]) begin
            bad++;
            if (first < 0) begin first = j; got = int'(clk_o[0]); expv = int'(expect_seq[j]); end
         end
      end
      report(bad == 0, "R9", $sformatf("reload sequence, first bad sample %0d", first),
             got, expv);
   endtask

   // R10 R11: tap alignment
   task automatic t_align();
      apply(8'h08, 8'h90, pack(3'd1, 3'd2, 3'd4, 3'd5, 3'd6, 3'd0), 6'h3F);
      check_align(0, 1, 1'b0, "R10 b1 /2 with N=8");
      check_align(2, 3, 1'b1, "R11 b2 /2 with N=16");
      check_align(2, 4, 1'b1, "R11 b2 /4 with N=16");
      apply(8'h06, 8'h8C, pack(3'd1, 3'd3, 3'd4, 3'd5, 3'd7, 3'd7), 6'h0F);
      check_align(0, 1, 1'b0, "R10 b1 /3 with N=6");
      check_align(2, 3, 1'b1, "R11 b2 /2 with N=12");
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge ref_clk);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_routes();
      t_packing();
      t_bounds();
      t_enable();
      t_reload();
      t_align();
      finish_run();
   end

endmodule